// File: doc/BRIEF.md
# Board Reset and Processor Start Sequencer

This block sequences the reset controls of an add-in board. A reset request starts an ordered pulse train. First a soft-reset control line is pulsed. Then a configuration-memory reload line is pulsed. Last, the on-board processor control register is written with zero. A start request takes the processor out of reset in two stages. The cold-reset bit is released on its own first. After a hold time, the cold-reset and warm-reset bits are released together. A final hold time follows before the sequence reports completion.

Every hold time is counted in ticks. A tick is a parameterised number of clocks, one millisecond by default at 100 MHz. The register-level outputs are a soft-reset level, a reload level, and a processor-control write strobe with its address and data. The address of the processor-control register depends on a board-revision input. A busy level and a one-cycle done pulse give the surrounding logic a simple handshake.

Top module: `board_seq_top`

## Requirements
- R1: After an accepted reset request, `soft_reset` is high for exactly SR_TICKS ticks, starting in the cycle after the request is sampled. It then stays low for SR_TICKS ticks.
- R2: Next, `eeprom_reload` is high for EE_TICKS ticks and then low for EE_TICKS ticks. `soft_reset` and `eeprom_reload` are never high together.
- R3: The reset sequence ends with a single write of all zeros to the processor-control register. The write comes in the cycle after the reload low phase ends.
- R4: After an accepted start request, the next cycle carries a write of the cold mask alone. The cold mask is bit 0, 32'h1 by default. A hold of COLD_TICKS ticks follows.
- R5: After that hold, a write of the cold mask OR the warm mask follows. The warm mask is bit 1, so the value is 32'h3 by default. A hold of WARM_TICKS ticks follows, and then the sequence completes.
- R6: `risc_wr` is a one-cycle strobe. `risc_ctrl` holds the last value written and is valid in the strobe cycle. `risc_addr` is OFS_NEW (default 8'h40) when `board_rev` is 1 and OFS_OLD (default 8'h20) when it is 0.
- R7: `busy` is high from the cycle after acceptance until the final state ends. `done` is high for exactly one cycle, with `busy` low, right after that.
- R8: A reset or start request that arrives while `busy` is high is ignored. The running sequence is unchanged and no second sequence follows it.
- R9: When both requests are sampled high in the same idle cycle, the reset sequence runs.
- R10: One tick lasts TICK_CLKS clock cycles. Every hold time is a whole number of ticks counted from entry into its step.
- R11: A synchronous active-high `rst` returns the block to idle. `busy`, `done`, `soft_reset`, `eeprom_reload` and `risc_wr` go low, and `risc_ctrl` returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req | input | 1 | Request for the board reset sequence |
| start_req | input | 1 | Request for the processor start sequence |
| board_rev | input | 1 | Board revision, selects the control-register offset |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |
| soft_reset | output | 1 | Bridge soft-reset control level |
| eeprom_reload | output | 1 | Configuration-memory reload control level |
| risc_wr | output | 1 | Write strobe for the processor-control register |
| risc_addr | output | ADDR_W | Offset of the processor-control register |
| risc_ctrl | output | DATA_W | Value written to the processor-control register |

## Verification
The bench compares every cycle of each sequence with a cycle-indexed expected pattern. A design that is off by one clock in a step, or that counts a hold in clocks rather than ticks, shows up in the first mismatching cycle.

Opposite requests are fired into running sequences at random cycles, including the last busy cycle. A design that accepts them would restart the sequence or launch a second one after `done`.

Simultaneous requests check that reset wins; a design with the wrong priority would emit the cold-mask write instead. A reset in the middle of a start sequence checks that the control word returns to zero and no strobe lingers.

// File: rtl/board_seq_pkg.sv
package board_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SR_ON,
        S_SR_OFF,
        S_EE_ON,
        S_EE_OFF,
        S_RCLR,
        S_COLD,
        S_WARM
    } seq_state_e;

    typedef enum logic [1:0] {
        W_NONE,
        W_CLEAR,
        W_COLD,
        W_RUN
    } risc_op_e;

    typedef struct packed {
        logic busy;
        logic soft_rst;
        logic ee_reload;
    } pin_set_t;

    function automatic pin_set_t pins_for(seq_state_e s);
        pin_set_t p;
        p.busy      = (s != S_IDLE);
        p.soft_rst  = (s == S_SR_ON);
        p.ee_reload = (s == S_EE_ON);
        return p;
    endfunction

    function automatic seq_state_e follow(seq_state_e s);
        case (s)
            S_SR_ON:  return S_SR_OFF;
            S_SR_OFF: return S_EE_ON;
            S_EE_ON:  return S_EE_OFF;
            S_EE_OFF: return S_RCLR;
            S_COLD:   return S_WARM;
            default:  return S_IDLE;
        endcase
    endfunction

    function automatic risc_op_e op_for(seq_state_e s);
        case (s)
            S_RCLR:  return W_CLEAR;
            S_COLD:  return W_COLD;
            S_WARM:  return W_RUN;
            default: return W_NONE;
        endcase
    endfunction

endpackage

// File: rtl/seq_tick_gen.sv
module seq_tick_gen #(
    parameter int TICK_CLKS = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int CW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CLKS - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    // R10: prescaler never passes the last clock of a tick
    p_tick_bound_r10: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import board_seq_pkg::*;
#(
    parameter int SR_TICKS   = 1,
    parameter int EE_TICKS   = 1,
    parameter int COLD_TICKS = 2,
    parameter int WARM_TICKS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reset_req,
    input  logic       start_req,
    input  logic       tick,
    output seq_state_e state,
    output logic       move,
    output risc_op_e   op_launch,
    output logic       done
);
    localparam int M1   = (SR_TICKS > EE_TICKS) ? SR_TICKS : EE_TICKS;
    localparam int M2   = (COLD_TICKS > WARM_TICKS) ? COLD_TICKS : WARM_TICKS;
    localparam int MAXT = (M1 > M2) ? M1 : M2;
    localparam int TW   = (MAXT > 1) ? $clog2(MAXT) : 1;

    seq_state_e    nxt;
    logic [TW-1:0] tick_cnt;
    logic [TW-1:0] last_idx;
    logic          finish;

    function automatic logic [TW-1:0] last_tick(seq_state_e s);
        case (s)
            S_SR_ON, S_SR_OFF: return TW'(SR_TICKS - 1);
            S_EE_ON, S_EE_OFF: return TW'(EE_TICKS - 1);
            S_COLD:            return TW'(COLD_TICKS - 1);
            S_WARM:            return TW'(WARM_TICKS - 1);
            default:           return '0;
        endcase
    endfunction

    assign last_idx = last_tick(state);

    always_comb begin
        nxt  = state;
        move = 1'b0;
        case (state)
            S_IDLE: begin
                if (reset_req) begin
                    nxt  = S_SR_ON;
                    move = 1'b1;
                end else if (start_req) begin
                    nxt  = S_COLD;
                    move = 1'b1;
                end
            end
            S_RCLR: begin
                nxt  = S_IDLE;
                move = 1'b1;
            end
            default: begin
                if (tick && tick_cnt == last_idx) begin
                    nxt  = follow(state);
                    move = 1'b1;
                end
            end
        endcase
    end

    assign finish    = move && (state == S_RCLR || state == S_WARM);
    assign op_launch = move ? op_for(nxt) : W_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            tick_cnt <= '0;
            done     <= 1'b0;
        end else begin
            state <= nxt;
            done  <= finish;
            if (move)      tick_cnt <= '0;
            else if (tick) tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // R2: reload pulse only ever follows the soft-reset low phase
    p_ee_order_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_EE_ON && $past(state) != S_EE_ON) |-> $past(state) == S_SR_OFF);

    // R5: combined release only ever follows the cold-only step
    p_warm_order_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_WARM && $past(state) != S_WARM) |-> $past(state) == S_COLD);

    // R8: a running step is left only when its hold expires
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && !(tick && tick_cnt == last_idx) && state != S_RCLR)
        |=> state == $past(state));

endmodule

// File: rtl/seq_risc_port.sv
module seq_risc_port
    import board_seq_pkg::*;
#(
    parameter int               DATA_W    = 32,
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] OFS_OLD  = 8'h20,
    parameter logic [ADDR_W-1:0] OFS_NEW  = 8'h40,
    parameter logic [DATA_W-1:0] COLD_MASK = 32'h1,
    parameter logic [DATA_W-1:0] WARM_MASK = 32'h2
) (
    input  logic              clk,
    input  logic              rst,
    input  risc_op_e          op,
    input  logic              board_rev,
    output logic              wr,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] value;

    always_comb begin
        case (op)
            W_COLD:  value = COLD_MASK;
            W_RUN:   value = COLD_MASK | WARM_MASK;
            default: value = '0;
        endcase
    end

    assign addr = board_rev ? OFS_NEW : OFS_OLD;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr   <= 1'b0;
            data <= '0;
        end else begin
            wr <= (op != W_NONE);
            if (op != W_NONE) data <= value;
        end
    end

    // R6: the write strobe is never longer than one cycle
    p_wr_oneshot_r6: assert property (@(posedge clk) disable iff (rst)
        wr |=> !wr);

    // R3: a clear request lands as zero data
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (op == W_CLEAR) |=> (wr && data == '0));

endmodule

// File: rtl/board_seq_top.sv
module board_seq_top
    import board_seq_pkg::*;
#(
    parameter int                TICK_CLKS  = 100000,
    parameter int                SR_TICKS   = 1,
    parameter int                EE_TICKS   = 1,
    parameter int                COLD_TICKS = 2,
    parameter int                WARM_TICKS = 10,
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] OFS_OLD    = 8'h20,
    parameter logic [ADDR_W-1:0] OFS_NEW    = 8'h40,
    parameter logic [DATA_W-1:0] COLD_MASK  = 32'h1,
    parameter logic [DATA_W-1:0] WARM_MASK  = 32'h2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reset_req,
    input  logic              start_req,
    input  logic              board_rev,
    output logic              busy,
    output logic              done,
    output logic              soft_reset,
    output logic              eeprom_reload,
    output logic              risc_wr,
    output logic [ADDR_W-1:0] risc_addr,
    output logic [DATA_W-1:0] risc_ctrl
);
    seq_state_e state;
    logic       move;
    logic       tick;
    risc_op_e   op_launch;
    pin_set_t   pins;

    seq_tick_gen #(.TICK_CLKS(TICK_CLKS)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (move),
        .tick    (tick)
    );

    seq_fsm #(
        .SR_TICKS   (SR_TICKS),
        .EE_TICKS   (EE_TICKS),
        .COLD_TICKS (COLD_TICKS),
        .WARM_TICKS (WARM_TICKS)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .reset_req (reset_req),
        .start_req (start_req),
        .tick      (tick),
        .state     (state),
        .move      (move),
        .op_launch (op_launch),
        .done      (done)
    );

    seq_risc_port #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .OFS_OLD   (OFS_OLD),
        .OFS_NEW   (OFS_NEW),
        .COLD_MASK (COLD_MASK),
        .WARM_MASK (WARM_MASK)
    ) u_port (
        .clk       (clk),
        .rst       (rst),
        .op        (op_launch),
        .board_rev (board_rev),
        .wr        (risc_wr),
        .addr      (risc_addr),
        .data      (risc_ctrl)
    );

    assign pins          = pins_for(state);
    assign busy          = pins.busy;
    assign soft_reset    = pins.soft_rst;
    assign eeprom_reload = pins.ee_reload;

    // R2: the two bridge controls are never driven together
    p_mutex_r2: assert property (@(posedge clk) disable iff (rst)
        !(soft_reset && eeprom_reload));

    // R7: done is a single pulse seen while idle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy ##1 !done));

    // R11: reset clears the control word and strobe
    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (!risc_wr && risc_ctrl == '0 && !busy));

endmodule

// File: tb/tb_board_seq_top.sv
module tb_board_seq_top;
    localparam int T     = 3;
    localparam int COLDT = 2;
    localparam int WARMT = 10;

    typedef struct packed {
        logic        busy;
        logic        done;
        logic        sr;
        logic        ee;
        logic        wr;
        logic [31:0] ctrl;
    } obs_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reset_req = 1'b0;
    logic        start_req = 1'b0;
    logic        board_rev = 1'b0;
    logic        busy, done, soft_reset, eeprom_reload, risc_wr;
    logic [7:0]  risc_addr;
    logic [31:0] risc_ctrl;

    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] prior = 32'h0;

    always #5 clk = ~clk;

    board_seq_top #(.TICK_CLKS(T)) dut (
        .clk(clk), .rst(rst), .reset_req(reset_req), .start_req(start_req),
        .board_rev(board_rev), .busy(busy), .done(done), .soft_reset(soft_reset),
        .eeprom_reload(eeprom_reload), .risc_wr(risc_wr), .risc_addr(risc_addr),
        .risc_ctrl(risc_ctrl)
    );

    function automatic obs_t exp_reset(int c, logic [31:0] pr);
        obs_t e;
        e.busy = (c <= 4*T);
        e.done = (c == 4*T + 1);
        e.sr   = (c < T);
        e.ee   = (c >= 2*T && c < 3*T);
        e.wr   = (c == 4*T);
        e.ctrl = (c >= 4*T) ? 32'h0 : pr;
        return e;
    endfunction

    function automatic obs_t exp_start(int c, logic [31:0] pr);
        obs_t e;
        e.busy = (c < (COLDT + WARMT)*T);
        e.done = (c == (COLDT + WARMT)*T);
        e.sr   = 1'b0;
        e.ee   = 1'b0;
        e.wr   = (c == 0 || c == COLDT*T);
        e.ctrl = (c < COLDT*T) ? 32'h1 : 32'h3;
        if (c < 0) e.ctrl = pr;
        return e;
    endfunction

    function automatic obs_t sample();
        obs_t o;
        o.busy = busy; o.done = done; o.sr = soft_reset;
        o.ee = eeprom_reload; o.wr = risc_wr; o.ctrl = risc_ctrl;
        return o;
    endfunction

    task automatic check(string req, obs_t got, obs_t want);
        n_run++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h at %0t", req, got, want, $time);
        end
    endtask

    task automatic check_addr();
        logic [7:0] want;
        want = board_rev ? 8'h40 : 8'h20;
        n_run++;
        if (risc_addr !== want) begin
            n_fail++;
            $display("FAIL R6 addr got=%h exp=%h", risc_addr, want);
        end
    endtask

    // is_start: 0 reset, 1 start; inj_at < 0 means no injection
    task automatic run_seq(bit is_start, bit both, int inj_at);
        int len;
        len = is_start ? (COLDT + WARMT)*T : 4*T + 1;
        @(negedge clk);
        if (is_start) start_req = 1'b1; else reset_req = 1'b1;
        if (both) begin reset_req = 1'b1; start_req = 1'b1; end
        @(negedge clk);
        reset_req = 1'b0; start_req = 1'b0;
        for (int c = 0; c <= len; c++) begin
            if (is_start) check("R4/R5/R7/R8", sample(), exp_start(c, prior));
            else          check(both ? "R9" : "R1/R2/R3/R7/R8", sample(), exp_reset(c, prior));
            check_addr();
            if (c == inj_at) begin
                reset_req = 1'b1; start_req = 1'b1;
            end
            @(negedge clk);
            reset_req = 1'b0; start_req = 1'b0;
        end
        prior = is_start ? 32'h3 : 32'h0;
        for (int k = 0; k < 3; k++) begin
            obs_t idle;
            idle = '0; idle.ctrl = prior;
            check("R8 idle after", sample(), idle);
            @(negedge clk);
        end
    endtask

    initial begin
        int seed;
        obs_t z;
        seed = 11;
        void'($urandom(seed));
        z = '0;
        repeat (3) @(negedge clk);
        check("R11 reset state", sample(), z);
        rst = 1'b0;
        @(negedge clk);

        run_seq(1'b0, 1'b0, -1);                       // R1 R2 R3 directed
        run_seq(1'b1, 1'b0, -1);                       // R4 R5 directed
        run_seq(1'b0, 1'b1, -1);                       // R9 both requests
        run_seq(1'b1, 1'b0, (COLDT + WARMT)*T - 1);    // R8 last busy cycle
        run_seq(1'b0, 1'b0, 4*T);                      // R8 during clear write

        for (int i = 0; i < 24; i++) begin
            bit st;
            int len, inj;
            st = 1'($urandom % 2);
            board_rev = 1'($urandom % 2);
            len = st ? (COLDT + WARMT)*T : 4*T + 1;
            inj = (($urandom % 3) == 0) ? -1 : int'($urandom % len);
            repeat ($urandom % 4) @(negedge clk);
            run_seq(st, 1'b0, inj);
        end

        // R11 mid-sequence reset
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (T*COLDT + 2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 mid-sequence", sample(), z);
        prior = 32'h0;
        run_seq(1'b0, 1'b0, -1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule